// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers the event and readiness signals of a UART into one 8-bit status word and raises a single interrupt line when any status bit is set and enabled by a matching bit in an 8-bit mask register. A level change on the clear-to-send pin and a transition of the received-break indication are each held in a sticky flag until software acknowledges them. The receive-readiness and transmit-readiness bits are live copies of flags that the receiver and transmitter provide.

Software reaches the block through a small register port with three locations. The status word at address 0 is read-only and always shows the true, unmasked state. The mask at address 1 can be read and written. The pin-change register at address 2 shows the flag and the synchronized pin level, and reading it acknowledges a clear-to-send change. The break flag is acknowledged by a dedicated command pulse. The block also gates host writes to the transmit holding register, so a character offered while the holder is full is dropped.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the status word reads 0x00 with all inputs low, the mask reads 0x00, and `irq` is 0.
- R2: In the status word, bits 6 down to 3 always read 0, and bit 0 equals `tx_ready` in the same cycle.
- R3: Status bit 1 equals `rx_fifo_full` when `rx_sel_full` is 1, and equals `rx_ready` when it is 0.
- R4: When `cos_enable` is 1, a level change on `cts_in` sets status bit 7 within four clock cycles. This passes through a two-stage synchronizer. The bit then stays set while the pin is steady.
- R5: A `cts_in` change that is synchronized while `cos_enable` is 0 is not recorded, and does not appear later when the enable returns to 1.
- R6: Reading address 2 returns the change flag in bit 4 and the synchronized `cts_in` level in bit 0, and clears the change flag. Reading the status word does not clear it.
- R7: Status bit 2 is set by a rising and also by a falling transition of `rx_break`, seen on the next clock edge, and is cleared by a `cmd_clr_break` pulse.
- R8: If a `rx_break` transition and `cmd_clr_break` arrive at the same clock edge, status bit 2 ends up set.
- R9: The status word shows set bits whatever the mask holds, and writes to addresses 0 and 2 change no register.
- R10: `irq` is a register that goes to 1 one clock after a cycle in which some status bit and its mask bit are both 1, and is 0 one clock after a cycle with no such pair. A mask write takes effect at the clock edge of the write.
- R11: `tx_load` is 1 only when `host_tx_wr` and `tx_ready` are both 1. A write offered while `tx_ready` is 0 is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_in | input | 1 | Clear-to-send pin, asynchronous |
| rx_break | input | 1 | Receiver break indication, synchronous |
| rx_ready | input | 1 | Receiver has a character |
| rx_fifo_full | input | 1 | Receive FIFO full |
| rx_sel_full | input | 1 | Mode bit: 1 selects FIFO-full for status bit 1 |
| tx_ready | input | 1 | Transmit holding register empty |
| cos_enable | input | 1 | Allows pin changes to set the change flag |
| cmd_clr_break | input | 1 | Command pulse that clears the break flag |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| host_tx_wr | input | 1 | Host offers a character to the transmitter |
| tx_load | output | 1 | Character accepted into the holding register |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach from the ports is a collision between a flag being set and being cleared at one clock edge. The bench brings it about by changing `rx_break` and raising `cmd_clr_break` at the same falling edge, so both are seen at the following rising edge. It then checks that the flag survives. The disabled-enable case is just as subtle. The bench keeps `cos_enable` low across the whole synchronizer delay after a pin change, then raises it, and shows that no stale event surfaces.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants for the UART interrupt status unit.
// Bit positions are behavioural: software decodes the status word by them.
package uart_irq_pkg;
    localparam int STAT_W   = 8;
    localparam int ADDR_W   = 2;
    // status word bit positions
    localparam int BIT_COS  = 7;
    localparam int BIT_DBRK = 2;
    localparam int BIT_RX   = 1;
    localparam int BIT_TX   = 0;
    // pin-change register bit positions
    localparam int CHG_FLAG = 4;
    localparam int CHG_LVL  = 0;

    typedef enum logic [ADDR_W-1:0] {
        A_STATUS = 2'd0,
        A_MASK   = 2'd1,
        A_CHANGE = 2'd2,
        A_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/cts_sync_edge.sv
// Module: cts_sync_edge
// Brings an asynchronous pin into the clock domain through a chain of
// STAGES flops and flags each change of the synchronized level.
// Assumes STAGES >= 2. Changes are reported only after the chain has been
// filled since reset, so the pin's reset-time level is not seen as an event.
module cts_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic toggle
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES:0]   fill_q;
    logic              level_d_q;

    // Purpose: shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    // Purpose: remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d_q <= 1'b0;
        else        level_d_q <= chain_q[STAGES-1];
    end

    // Purpose: track how far the chain has filled with real samples.
    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= {fill_q[STAGES-1:0], 1'b1};
    end

    assign level  = chain_q[STAGES-1];
    assign toggle = (chain_q[STAGES-1] ^ level_d_q) & fill_q[STAGES];

    // R4: a reported change always leaves the level different from before
    p_toggle_moves_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (level_d_q != $past(level_d_q)))
        else $error("toggle without level step");
endmodule

// File: rtl/sticky_flag.sv
// Module: sticky_flag
// One event flag: a set pulse latches it, a clear pulse drops it.
// Assumes set and clear are synchronous pulses. Set wins when both coincide.
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Purpose: hold the event until acknowledged, set over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R8: a set in the same cycle as a clear still leaves the flag latched
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o)
        else $error("set lost");
    // R7: a lone clear drops the flag
    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o)
        else $error("clear ignored");
    // R7: without set or clear the flag holds
    p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o))
        else $error("flag moved by itself");
endmodule

// File: rtl/irq_reg_port.sv
// Module: irq_reg_port
// Register access for the interrupt unit: holds the mask, muxes read data
// and produces the read-acknowledge pulse for the pin-change flag.
// Assumes single-cycle strobes. Read data is combinational from the address.
module irq_reg_port
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    input  logic [STAT_W-1:0] status,
    input  logic              cts_level,
    input  logic              cos_flag,
    output logic [STAT_W-1:0] reg_rdata,
    output logic [STAT_W-1:0] mask,
    output logic              chg_ack
);
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] change_word;

    // Purpose: the mask is the only writable register; other writes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_wr && reg_addr == A_MASK)
            mask_q <= reg_wdata;
    end

    // Purpose: assemble the pin-change register view.
    always_comb begin
        change_word           = '0;
        change_word[CHG_FLAG] = cos_flag;
        change_word[CHG_LVL]  = cts_level;
    end

    // Purpose: select read data by address.
    always_comb begin
        unique case (reg_addr)
            A_STATUS: reg_rdata = status;
            A_MASK:   reg_rdata = mask_q;
            A_CHANGE: reg_rdata = change_word;
            default:  reg_rdata = '0;
        endcase
    end

    assign mask    = mask_q;
    assign chg_ack = reg_rd && (reg_addr == A_CHANGE);

    // R1: reset leaves the mask cleared
    p_mask_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0))
        else $error("mask not cleared by reset");
    // R9: the mask moves only on a write to its own address
    p_mask_only_own_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_MASK) |=> $stable(mask_q))
        else $error("mask changed without write");
endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: uart_irq_ctrl (top)
// Collects UART event and readiness sources into a status word, masks it,
// and drives one registered interrupt request. Also gates host writes to
// the transmit holding register on its empty flag.
// Assumes rx_break, rx_ready, rx_fifo_full, tx_ready and command pulses are
// synchronous to clk. cts_in may be asynchronous.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_in,
    input  logic              rx_break,
    input  logic              rx_ready,
    input  logic              rx_fifo_full,
    input  logic              rx_sel_full,
    input  logic              tx_ready,
    input  logic              cos_enable,
    input  logic              cmd_clr_break,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic              host_tx_wr,
    output logic              tx_load,
    output logic              irq
);
    logic              cts_level;
    logic              cts_toggle;
    logic              cos_set;
    logic              cos_flag;
    logic              chg_ack;
    logic              brk_d_q;
    logic              brk_edge;
    logic              dbrk_flag;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] mask;
    logic              irq_q;

    cts_sync_edge #(.STAGES(SYNC_STAGES)) u_cts (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_in),
        .level    (cts_level),
        .toggle   (cts_toggle)
    );

    assign cos_set = cts_toggle & cos_enable;

    sticky_flag u_cos_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cos_set),
        .clr_i  (chg_ack),
        .flag_o (cos_flag)
    );

    // Purpose: previous break level, so both break start and end are seen.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_d_q <= 1'b0;
        else        brk_d_q <= rx_break;
    end

    assign brk_edge = rx_break ^ brk_d_q;

    sticky_flag u_brk_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (brk_edge),
        .clr_i  (cmd_clr_break),
        .flag_o (dbrk_flag)
    );

    // Purpose: build the status word; unused positions stay zero.
    always_comb begin
        status           = '0;
        status[BIT_COS]  = cos_flag;
        status[BIT_DBRK] = dbrk_flag;
        status[BIT_RX]   = rx_sel_full ? rx_fifo_full : rx_ready;
        status[BIT_TX]   = tx_ready;
    end

    irq_reg_port u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (status),
        .cts_level (cts_level),
        .cos_flag  (cos_flag),
        .reg_rdata (reg_rdata),
        .mask      (mask),
        .chg_ack   (chg_ack)
    );

    // Purpose: registered interrupt so the line never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status & mask);
    end

    assign irq     = irq_q;
    assign tx_load = host_tx_wr & tx_ready;

    // R10: with an empty mask the interrupt stays low
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq)
        else $error("interrupt with empty mask");
    // R5: the change flag only rises while the enable was on
    p_cos_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cos_flag) |-> $past(cos_enable))
        else $error("change flag without enable");
    // R1: reset leaves the interrupt low
    p_irq_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !irq)
        else $error("interrupt after reset");
endmodule

// File: tb/uart_irq_ctrl_tb.sv
// Directed bench for uart_irq_ctrl: one task per scenario.
module uart_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_in = 1'b0, rx_break = 1'b0, rx_ready = 1'b0, rx_fifo_full = 1'b0;
    logic       rx_sel_full = 1'b0, tx_ready = 1'b0, cos_enable = 1'b0, cmd_clr_break = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       host_tx_wr = 1'b0;
    logic       tx_load, irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .rx_break(rx_break),
        .rx_ready(rx_ready), .rx_fifo_full(rx_fifo_full), .rx_sel_full(rx_sel_full),
        .tx_ready(tx_ready), .cos_enable(cos_enable), .cmd_clr_break(cmd_clr_break),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_tx_wr(host_tx_wr), .tx_load(tx_load), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // called at a falling edge; returns the combinational read data
    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, d); check("R1 status after reset", d, 8'h00);
        rd(2'd1, d); check("R1 mask after reset", d, 8'h00);
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] d;
        tx_ready = 1'b1;
        rd(2'd0, d); check("R2 tx bit set, 6..3 zero", d, 8'h01);
        tx_ready = 1'b0;
        rd(2'd0, d); check("R2 tx bit clear", d, 8'h00);
    endtask

    task automatic t_rx_select();
        logic [7:0] d;
        rx_ready = 1'b1; rx_fifo_full = 1'b0; rx_sel_full = 1'b0;
        rd(2'd0, d); check("R3 ready selected", d, 8'h02);
        rx_sel_full = 1'b1;
        rd(2'd0, d); check("R3 full selected, full=0", d, 8'h00);
        rx_fifo_full = 1'b1; rx_ready = 1'b0;
        rd(2'd0, d); check("R3 full selected, full=1", d, 8'h02);
        rx_fifo_full = 1'b0; rx_sel_full = 1'b0;
    endtask

    task automatic t_cos_disabled();
        logic [7:0] d;
        cos_enable = 1'b0;
        cts_in = 1'b1;
        wait_cyc(6);
        cos_enable = 1'b1;
        wait_cyc(4);
        rd(2'd0, d); check("R5 disabled change not recorded", d, 8'h00);
        rd(2'd2, d); check("R5 level visible, no flag", d, 8'h01);
    endtask

    task automatic t_cos_enabled();
        logic [7:0] d;
        cos_enable = 1'b1;
        cts_in = 1'b0;
        wait_cyc(4);
        rd(2'd0, d); check("R4 falling change sets flag", d, 8'h80);
        wait_cyc(3);
        rd(2'd0, d); check("R6 status read does not clear", d, 8'h80);
        rd(2'd2, d); check("R6 change reg flag and level", d, 8'h10);
        rd(2'd0, d); check("R6 flag cleared by change read", d, 8'h00);
        cts_in = 1'b1;
        wait_cyc(4);
        rd(2'd2, d); check("R4 rising change sets flag", d, 8'h11);
        rd(2'd2, d); check("R6 second read shows cleared", d, 8'h01);
    endtask

    task automatic t_break();
        logic [7:0] d;
        rx_break = 1'b1;
        @(negedge clk);
        rd(2'd0, d); check("R7 break start sets flag", d, 8'h04);
        cmd_clr_break = 1'b1; @(negedge clk); cmd_clr_break = 1'b0;
        rd(2'd0, d); check("R7 command clears flag", d, 8'h00);
        rx_break = 1'b0;
        @(negedge clk);
        rd(2'd0, d); check("R7 break end sets flag", d, 8'h04);
        cmd_clr_break = 1'b1; @(negedge clk); cmd_clr_break = 1'b0;
        // collision: new edge and clear at the same clock edge
        rx_break = 1'b1; cmd_clr_break = 1'b1;
        @(negedge clk);
        rx_break = 1'b1; cmd_clr_break = 1'b0;
        rd(2'd0, d); check("R8 set wins over clear", d, 8'h04);
    endtask

    task automatic t_unmasked_and_ro();
        logic [7:0] d;
        rd(2'd1, d); check("R9 mask still zero", d, 8'h00);
        check("R9 irq low while masked", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'hFF);
        rd(2'd0, d); check("R9 status unchanged by write", d, 8'h04);
        rd(2'd1, d); check("R9 mask unchanged by other writes", d, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(2'd1, 8'h04);
        check("R10 irq not yet high at mask write edge", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R10 irq high one cycle later", {7'd0, irq}, 8'h01);
        rd(2'd1, d); check("R10 mask readback", d, 8'h04);
        cmd_clr_break = 1'b1; @(negedge clk); cmd_clr_break = 1'b0;
        check("R10 irq still high at clear edge", {7'd0, irq}, 8'h01);
        @(negedge clk);
        check("R10 irq low after source cleared", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h01);
        tx_ready = 1'b1;
        wait_cyc(2);
        check("R10 tx source raises irq", {7'd0, irq}, 8'h01);
        wr(2'd1, 8'h00);
        @(negedge clk);
        check("R10 mask off drops irq", {7'd0, irq}, 8'h00);
        tx_ready = 1'b0;
    endtask

    task automatic t_tx_gate();
        host_tx_wr = 1'b1; tx_ready = 1'b0;
        #1 check("R11 write discarded when not ready", {7'd0, tx_load}, 8'h00);
        tx_ready = 1'b1;
        #1 check("R11 write accepted when ready", {7'd0, tx_load}, 8'h01);
        host_tx_wr = 1'b0;
        #1 check("R11 no load without write", {7'd0, tx_load}, 8'h00);
        tx_ready = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        reg_addr = 2'd3;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(6);
        t_reset();
        t_layout();
        t_rx_select();
        t_cos_disabled();
        t_cos_enabled();
        t_break();
        t_unmasked_and_ro();
        t_irq();
        t_tx_gate();
        finish_run();
    end
endmodule